// File: doc/BRIEF.md
# Graphics Port Error Capture Unit

This block logs error events for a graphics-port bridge and for the table that remaps the port's addresses. Detector logic elsewhere in the bridge raises single-cycle pulses, one per error class. The unit sorts these pulses into three 8-bit status registers. The port first-error register holds only the errors of the cycle in which the port first failed. The port next-error register collects every port error after that. A separate first-error register keeps the first address-translation fault. The unit also counts outstanding port requests, so that it can raise a queue-overflow error itself.

Software reads the registers through a small address/data port and clears bits by writing ones to them. The status registers are sticky: a warm reset leaves them unchanged, and only a power-on reset clears them. The warm reset clears the request count and the read-data register.

Top module: `gfx_port_err_log`

## Requirements
- R1: After power-on reset, every register reads 00h. Address 0 selects the port first-error register, 1 selects the port next-error register, 2 selects the translation first-error register, and 3 reads 00h. In the port registers, bits 7:6 always read 0. In the translation register, bits 7:4 and bit 0 always read 0.
- R2: When the port first-error register reads zero, the errors raised in a cycle are latched into it together. The bits are: 5 low-priority read-data parity, 4 high-priority read-data parity, 3 pipelined request while sideband addressing is on, 2 request address with bits 63:40 not zero, 1 request queue overflow, 0 illegal command. While it is nonzero, only clears change it.
- R3: While the port first-error register is nonzero, each new port error sets its bit in the next-error register. Errors latched into the first-error register are not set in the next-error register.
- R4: The outstanding-request count rises by one on an accepted request and falls by one on a completion. It does not change when both arrive in the same cycle. It saturates at 16 and stops at 0. A request that arrives without a completion while 16 are outstanding raises the overflow error (bit 1).
- R5: The translation first-error register latches the faults of a cycle only while it reads zero: bit 3 table parity, bit 2 invalid table entry, bit 1 illegal translated address. Faults that arrive while it is nonzero are dropped.
- R6: A write clears each bit of the addressed register for which the write data holds a 1 and leaves the other bits unchanged.
- R7: A clear and a new error on the same next-error bit in the same cycle leave that bit set.
- R8: Warm reset keeps all three status registers. It clears the request count and the read data. Power-on reset clears everything.
- R9: Read data is registered. It shows the addressed register as it was at the clock edge that sampled the address, and it appears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high |
| ev_rd_par_lo | input | 1 | Parity error on low-priority read data |
| ev_rd_par_hi | input | 1 | Parity error on high-priority read data |
| ev_pipe_in_sb | input | 1 | Pipelined request while sideband addressing is on |
| ev_addr_upper | input | 1 | Request address has upper bits set |
| ev_bad_cmd | input | 1 | Illegal command |
| req_accept | input | 1 | New port request arrives |
| req_done | input | 1 | An outstanding request completes |
| ev_tbl_par | input | 1 | Remap table parity error |
| ev_tbl_invalid | input | 1 | Remap table entry invalid |
| ev_xlat_addr | input | 1 | Translated address is illegal |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe (write-one-to-clear) |
| reg_wdata | input | 8 | Clear mask |
| reg_rdata | output | 8 | Registered read data |

## Verification
The assertions assume that power-on reset is asserted from the first clock edge. They also assume that error pulses are synchronous to the clock and last one cycle each. The bench holds power-on reset high during the first cycles. It drives every input at the falling edge, so the pulses always sit cleanly within one cycle. Random stimulus sends requests more often than completions, so the count reaches and stays near its limit of 16. Occasional warm and power-on resets are mixed in, so the sticky behaviour and the clearing of the count are exercised as well.

// File: rtl/gel_pkg.sv
package gel_pkg;
  localparam int REG_W = 8;
  // Port error bit positions (software decodes these)
  localparam int B_CMD   = 0;
  localparam int B_OVF   = 1;
  localparam int B_ADDR  = 2;
  localparam int B_PIPE  = 3;
  localparam int B_PARHI = 4;
  localparam int B_PARLO = 5;
  // Translation error bit positions
  localparam int B_XADDR = 1;
  localparam int B_TINV  = 2;
  localparam int B_TPAR  = 3;
  localparam logic [REG_W-1:0] PORT_MASK = 8'h3F;
  localparam logic [REG_W-1:0] XLAT_MASK = 8'h0E;
  typedef enum logic [1:0] {
    SEL_PFIRST = 2'd0,
    SEL_PNEXT  = 2'd1,
    SEL_XFIRST = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gel_req_track.sv
module gel_req_track #(
  parameter int MAX_OUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req_accept,
  input  logic req_done,
  output logic ovf_o
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam logic [CW-1:0] FULL_V = CW'(MAX_OUT);

  logic [CW-1:0] cnt_q;
  logic          full;

  always_comb begin
    full  = (cnt_q == FULL_V);
    ovf_o = ~rst & req_accept & ~req_done & full;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (req_accept && !req_done && !full)
      cnt_q <= cnt_q + 1'b1;
    else if (req_done && !req_accept && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_V);
  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL_V && req_accept && !req_done) |=> cnt_q == FULL_V);
  a_r4_balanced: assert property (@(posedge clk) disable iff (rst)
    (req_accept && req_done) |=> $stable(cnt_q));
endmodule

// File: rtl/gel_err_bank.sv
module gel_err_bank #(
  parameter int               W        = 8,
  parameter logic [W-1:0]     MASK     = '1,
  parameter bit               HAS_NEXT = 1'b1
) (
  input  logic         clk,
  input  logic         por,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr_first,
  input  logic [W-1:0] clr_next,
  output logic [W-1:0] first_q,
  output logic [W-1:0] next_q
);
  logic [W-1:0] ev_m;
  logic         busy;

  always_comb begin
    ev_m = ev & MASK;
    busy = (first_q != '0);
  end

  always_ff @(posedge clk) begin
    if (por)
      first_q <= '0;
    else if (busy)
      first_q <= first_q & ~clr_first;
    else
      first_q <= ev_m;
  end

  generate
    if (HAS_NEXT) begin : g_next
      always_ff @(posedge clk) begin
        if (por)
          next_q <= '0;
        else
          next_q <= (next_q & ~clr_next) | (busy ? ev_m : '0);
      end

      a_r3_next_quiet: assert property (@(posedge clk) disable iff (por)
        (first_q == '0 && clr_next == '0) |=> $stable(next_q));
      a_r7_set_wins: assert property (@(posedge clk) disable iff (por)
        (first_q != '0) |=> ((next_q & $past(ev_m)) == $past(ev_m)));
    end else begin : g_no_next
      assign next_q = '0;
    end
  endgenerate

  a_r2_first_hold: assert property (@(posedge clk) disable iff (por)
    (first_q != '0 && clr_first == '0) |=> $stable(first_q));
  a_r1_reserved: assert property (@(posedge clk) disable iff (por)
    (first_q & ~MASK) == '0);
endmodule

// File: rtl/gfx_port_err_log.sv
module gfx_port_err_log
  import gel_pkg::*;
#(
  parameter int MAX_OUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             ev_rd_par_lo,
  input  logic             ev_rd_par_hi,
  input  logic             ev_pipe_in_sb,
  input  logic             ev_addr_upper,
  input  logic             ev_bad_cmd,
  input  logic             req_accept,
  input  logic             req_done,
  input  logic             ev_tbl_par,
  input  logic             ev_tbl_invalid,
  input  logic             ev_xlat_addr,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  logic             ovf;
  logic [REG_W-1:0] port_ev, xlat_ev;
  logic [REG_W-1:0] clr_pf, clr_pn, clr_xf;
  logic [REG_W-1:0] pf_q, pn_q, xf_q, xn_unused;
  reg_sel_e         sel;

  gel_req_track #(.MAX_OUT(MAX_OUT)) u_track (
    .clk(clk), .rst(rst | por),
    .req_accept(req_accept), .req_done(req_done), .ovf_o(ovf)
  );

  always_comb begin
    port_ev = '0;
    port_ev[B_CMD]   = ev_bad_cmd;
    port_ev[B_OVF]   = ovf;
    port_ev[B_ADDR]  = ev_addr_upper;
    port_ev[B_PIPE]  = ev_pipe_in_sb;
    port_ev[B_PARHI] = ev_rd_par_hi;
    port_ev[B_PARLO] = ev_rd_par_lo;
    xlat_ev = '0;
    xlat_ev[B_XADDR] = ev_xlat_addr;
    xlat_ev[B_TINV]  = ev_tbl_invalid;
    xlat_ev[B_TPAR]  = ev_tbl_par;
    sel    = reg_sel_e'(reg_addr);
    clr_pf = (reg_we && sel == SEL_PFIRST) ? reg_wdata : '0;
    clr_pn = (reg_we && sel == SEL_PNEXT)  ? reg_wdata : '0;
    clr_xf = (reg_we && sel == SEL_XFIRST) ? reg_wdata : '0;
  end

  gel_err_bank #(.W(REG_W), .MASK(PORT_MASK), .HAS_NEXT(1'b1)) u_port (
    .clk(clk), .por(por), .ev(port_ev),
    .clr_first(clr_pf), .clr_next(clr_pn),
    .first_q(pf_q), .next_q(pn_q)
  );

  gel_err_bank #(.W(REG_W), .MASK(XLAT_MASK), .HAS_NEXT(1'b0)) u_xlat (
    .clk(clk), .por(por), .ev(xlat_ev),
    .clr_first(clr_xf), .clr_next('0),
    .first_q(xf_q), .next_q(xn_unused)
  );

  always_ff @(posedge clk) begin
    if (rst || por)
      reg_rdata <= '0;
    else begin
      unique case (sel)
        SEL_PFIRST: reg_rdata <= pf_q;
        SEL_PNEXT:  reg_rdata <= pn_q;
        SEL_XFIRST: reg_rdata <= xf_q;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  a_r9_unused_addr: assert property (@(posedge clk) disable iff (por)
    (reg_addr == 2'd3) |=> reg_rdata == '0);
  a_r8_sticky: assert property (@(posedge clk) disable iff (por)
    (rst && port_ev == '0 && clr_pf == '0) |=> $stable(pf_q));
  a_r1_rd_reserved: assert property (@(posedge clk) disable iff (por)
    reg_rdata[7:6] == 2'b00);
endmodule

// File: tb/gfx_port_err_log_tb.sv
`timescale 1ns/1ps
module gfx_port_err_log_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b0, por = 1'b1;
  logic lo = 0, hi = 0, pipe = 0, ahi = 0, cmd = 0, acc = 0, done = 0;
  logic tp = 0, ti = 0, tx = 0;
  logic [1:0] addr = 2'd0;
  logic we = 0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;

  gfx_port_err_log dut_i (
    .clk(clk), .rst(rst), .por(por),
    .ev_rd_par_lo(lo), .ev_rd_par_hi(hi), .ev_pipe_in_sb(pipe),
    .ev_addr_upper(ahi), .ev_bad_cmd(cmd),
    .req_accept(acc), .req_done(done),
    .ev_tbl_par(tp), .ev_tbl_invalid(ti), .ev_xlat_addr(tx),
    .reg_addr(addr), .reg_we(we), .reg_wdata(wd), .reg_rdata(rdata)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_f = 0, m_n = 0, m_t = 0;
  int m_cnt = 0;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    lo = 0; hi = 0; pipe = 0; ahi = 0; cmd = 0; acc = 0; done = 0;
    tp = 0; ti = 0; tx = 0; we = 0; wd = 0; rst = 0; por = 0;
  endtask

  // Advance one cycle with the current inputs; predict and check read data.
  task automatic cyc(input string tag);
    logic [7:0] c0, c1, c2, pe, te, rd_e;
    logic ovf;
    c0 = (we && addr == 2'd0) ? wd : 8'h00;
    c1 = (we && addr == 2'd1) ? wd : 8'h00;
    c2 = (we && addr == 2'd2) ? wd : 8'h00;
    if (por) begin
      rd_e = 0; m_f = 0; m_n = 0; m_t = 0; m_cnt = 0;
    end else begin
      case (addr)
        2'd0: rd_e = m_f;
        2'd1: rd_e = m_n;
        2'd2: rd_e = m_t;
        default: rd_e = 8'h00;
      endcase
      if (rst) rd_e = 8'h00;
      ovf = !rst && acc && !done && (m_cnt == 16);
      pe = {2'b00, lo, hi, pipe, ahi, ovf, cmd};
      te = {4'b0000, tp, ti, tx, 1'b0};
      m_n = (m_n & ~c1) | ((m_f != 0) ? pe : 8'h00);
      m_f = (m_f != 0) ? (m_f & ~c0) : pe;
      m_t = (m_t != 0) ? (m_t & ~c2) : te;
      if (rst) m_cnt = 0;
      else if (acc && !done && m_cnt < 16) m_cnt++;
      else if (done && !acc && m_cnt > 0) m_cnt--;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rdata, rd_e, tag);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    idle(); addr = a; cyc(tag);
    chk(rdata, exp, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    por = 1; cyc("R8"); cyc("R8");
    // R1 reset state
    rd(2'd0, 8'h00, "R1"); rd(2'd1, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1"); rd(2'd3, 8'h00, "R1");
    // R2 simultaneous first errors
    idle(); cmd = 1; pipe = 1; cyc("R2");
    rd(2'd0, 8'h09, "R2");
    // R3 later errors go to next register
    idle(); cmd = 1; lo = 1; cyc("R3");
    rd(2'd0, 8'h09, "R3"); rd(2'd1, 8'h21, "R3");
    // R6 partial clear of first register
    idle(); we = 1; addr = 2'd0; wd = 8'h08; cyc("R6");
    rd(2'd0, 8'h01, "R6");
    // R7 clear and set of same next bit
    idle(); we = 1; addr = 2'd1; wd = 8'hFF; hi = 1; cyc("R7");
    rd(2'd1, 8'h10, "R7");
    // R5 translation first, later faults dropped
    idle(); ti = 1; cyc("R5");
    idle(); tp = 1; tx = 1; cyc("R5");
    rd(2'd2, 8'h04, "R5");
    // R9 read shows state before the same-edge update
    idle(); addr = 2'd1; ahi = 1; cyc("R9");
    chk(rdata, 8'h10, "R9");
    rd(2'd1, 8'h14, "R9");
    // R8 warm reset keeps status
    idle(); rst = 1; addr = 2'd0; cyc("R8"); chk(rdata, 8'h00, "R8");
    rd(2'd0, 8'h01, "R8"); rd(2'd2, 8'h04, "R8");
    // clear everything
    idle(); we = 1; wd = 8'hFF; addr = 2'd0; cyc("R6");
    idle(); we = 1; wd = 8'hFF; addr = 2'd1; cyc("R6");
    idle(); we = 1; wd = 8'hFF; addr = 2'd2; cyc("R6");
    rd(2'd0, 8'h00, "R6"); rd(2'd1, 8'h00, "R6"); rd(2'd2, 8'h00, "R6");
    // R4 fill to 16, then overflow
    for (int i = 0; i < 16; i++) begin idle(); acc = 1; cyc("R4"); end
    rd(2'd0, 8'h00, "R4");
    idle(); acc = 1; done = 1; cyc("R4");
    rd(2'd0, 8'h00, "R4");
    idle(); acc = 1; cyc("R4");
    rd(2'd0, 8'h02, "R4");
    idle(); done = 1; cyc("R4");
    idle(); acc = 1; cyc("R4");
    rd(2'd1, 8'h00, "R4");
    idle(); acc = 1; cyc("R4");
    rd(2'd1, 8'h02, "R4");
    // R8 warm reset clears the count
    idle(); rst = 1; cyc("R8");
    for (int i = 0; i < 16; i++) begin idle(); acc = 1; cyc("R8"); end
    rd(2'd1, 8'h02, "R8");
    idle(); we = 1; wd = 8'hFF; addr = 2'd1; cyc("R8");
    idle(); acc = 1; cyc("R8");
    rd(2'd1, 8'h02, "R8");
    // R8 power-on reset clears all
    idle(); por = 1; cyc("R8");
    rd(2'd0, 8'h00, "R8"); rd(2'd1, 8'h00, "R8");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      idle();
      lo = ($urandom % 10) == 0; hi = ($urandom % 10) == 0;
      pipe = ($urandom % 12) == 0; ahi = ($urandom % 12) == 0;
      cmd = ($urandom % 12) == 0;
      tp = ($urandom % 12) == 0; ti = ($urandom % 12) == 0;
      tx = ($urandom % 12) == 0;
      acc = ($urandom % 10) < 6; done = ($urandom % 10) < 3;
      addr = 2'($urandom % 4);
      we = ($urandom % 5) == 0;
      wd = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
      rst = ($urandom % 150) == 0;
      por = ($urandom % 400) == 0;
      case (addr)
        2'd0: cyc("R2");
        2'd1: cyc("R3");
        2'd2: cyc("R5");
        default: cyc("R1");
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule